// File: doc/BRIEF.md
# Dual-Band Tone Period Detector

This block identifies touch-tone key presses from two square waves. An external front end band-splits and hard-limits the line signal. It then supplies one logic wave that toggles at the low-band tone frequency and one that toggles at the high-band tone frequency. The detector runs from a fixed reference clock. For each band it counts the clocks between successive rising edges, then compares every measured period against four per-tone acceptance windows. These windows are derived at elaboration time from the clock frequency and a tolerance parameter.

A band becomes valid only after several consecutive periods agree on the same tone. It loses that status after two consecutive out-of-window periods. It also loses it when no edge arrives within the longest period its band can accept. While both bands are valid at once, `early_steer` is high and `digit_code` carries the 4-bit key code of the pair. Guard-time validation and output latching belong to the logic downstream.

Top module: `dtmf_period_detector`

## Requirements
- R1: After reset, `early_steer` is 0 and `digit_code` is 0.
- R2: Each input is measured from rising edge to rising edge after a two-stage synchroniser. Low-band tones are 697, 770, 852 and 941 Hz (rows 0 to 3). High-band tones are 1209, 1336, 1477 and 1633 Hz (columns 0 to 3). A band becomes valid once RUN_LEN (default 4) consecutive periods fall in the same tone's window.
- R3: A tone within 1.5% plus 2 Hz of its nominal frequency, in either direction, is accepted.
- R4: A tone 3.5% or more away from every nominal frequency of its band is rejected, and `early_steer` stays 0.
- R5: `early_steer` is 1 only while both bands are valid; a single valid band leaves it 0.
- R6: A band whose input shows no rising edge for longer than the maximum accepted period of its lowest tone becomes invalid, so `early_steer` falls. The period counter never wraps.
- R7: While a band is valid, a single out-of-window period does not clear it. Two consecutive out-of-window periods do clear it. `digit_code` does not change while `early_steer` stays high.
- R8: The code depends on row r and column c of the keypad. The keypad rows are "1 2 3 A", "4 5 6 B", "7 8 9 C" and "* 0 #  D". Digits 1 to 9 give 1 to 9, 0 gives 10, * gives 11 and # gives 12. A, B and C give 13, 14 and 15, and D gives 0.
- R9: `digit_code` is 0 whenever `early_steer` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of CLK_HZ hertz |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_lo_i | input | 1 | Limited low-band square wave |
| tone_hi_i | input | 1 | Limited high-band square wave |
| early_steer | output | 1 | Both bands hold a valid tone |
| digit_code | output | 4 | Key code of the detected pair, 0 when idle |

## Verification
On every cycle, the assertions check several timing relations. A band can only turn valid in the cycle after a measured edge, and `early_steer` can only rise after one. A timeout always clears its band, the period counters never wrap, and the code stays fixed while steering holds. The bench scenarios cover the rest, which the assertions cannot show. These are the mapping of all sixteen pairs, the accept and reject edges of the frequency tolerance, the single-band case, the timeout after a tone stops, and the difference between one bad period and two.

// File: rtl/dtmf_period_detector.sv
module dtmf_period_detector #(
  parameter int CLK_HZ     = 3579545,
  parameter int TOL_PERMIL = 25,
  parameter int RUN_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_lo_i,
  input  logic       tone_hi_i,
  output logic       early_steer,
  output logic [3:0] digit_code
);

  function automatic int tone_hz(int g, int i);
    int lo [4] = '{697, 770, 852, 941};
    int hi [4] = '{1209, 1336, 1477, 1633};
    return (g == 0) ? lo[i] : hi[i];
  endfunction

  function automatic int pmin(int g, int i);
    return int'((longint'(CLK_HZ) * 1000) / (longint'(tone_hz(g, i)) * (1000 + TOL_PERMIL)));
  endfunction

  function automatic int pmax(int g, int i);
    return int'((longint'(CLK_HZ) * 1000) / (longint'(tone_hz(g, i)) * (1000 - TOL_PERMIL)));
  endfunction

  function automatic logic [3:0] key_code(logic [1:0] r, logic [1:0] c);
    if (c == 2'd3) return (r == 2'd3) ? 4'd0 : 4'(13 + int'(r));
    if (r == 2'd3) begin
      case (c)
        2'd0:    return 4'd11;
        2'd1:    return 4'd10;
        default: return 4'd12;
      endcase
    end
    return 4'(3 * int'(r) + int'(c) + 1);
  endfunction

  localparam int CW = $clog2(pmax(0, 0) + 2);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [1:0]    sq_in;
  logic [1:0]    grp_valid, grp_edge, grp_tmo;
  logic [1:0]    grp_tone [2];
  logic [CW-1:0] grp_cnt  [2];

  assign sq_in = {tone_hi_i, tone_lo_i};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int TMO = pmax(g, 0);

    logic [2:0]    sync_q;
    logic          armed_q, valid_q, miss_q;
    logic [CW-1:0] cnt_q;
    logic [RW-1:0] run_q, run_nx;
    logic [1:0]    cand_q, tone_q, idx;
    logic          rise, tmo, hit;

    assign rise = sync_q[1] & ~sync_q[2];
    assign tmo  = armed_q & ~rise & (cnt_q == CW'(TMO));

    always_comb begin
      hit = 1'b0;
      idx = 2'd0;
      for (int i = 0; i < 4; i++)
        if (cnt_q >= CW'(pmin(g, i)) && cnt_q <= CW'(pmax(g, i))) begin
          hit = 1'b1;
          idx = 2'(i);
        end
      if (!hit)
        run_nx = '0;
      else if (idx == cand_q && run_q != '0)
        run_nx = (run_q == RW'(RUN_LEN)) ? run_q : run_q + 1'b1;
      else
        run_nx = RW'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q  <= '0;
        armed_q <= 1'b0;
        valid_q <= 1'b0;
        miss_q  <= 1'b0;
        cnt_q   <= '0;
        run_q   <= '0;
        cand_q  <= '0;
        tone_q  <= '0;
      end else begin
        sync_q <= {sync_q[1:0], sq_in[g]};
        if (rise) begin
          cnt_q   <= CW'(1);
          armed_q <= 1'b1;
          if (armed_q) begin
            run_q <= run_nx;
            if (hit) cand_q <= idx;
            if (run_nx == RW'(RUN_LEN)) begin
              valid_q <= 1'b1;
              tone_q  <= idx;
              miss_q  <= 1'b0;
            end else if (valid_q) begin
              if (hit && idx == tone_q) miss_q <= 1'b0;
              else if (miss_q) begin
                valid_q <= 1'b0;
                miss_q  <= 1'b0;
              end else miss_q <= 1'b1;
            end
          end
        end else if (tmo) begin
          armed_q <= 1'b0;
          valid_q <= 1'b0;
          miss_q  <= 1'b0;
          run_q   <= '0;
        end else if (armed_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign grp_valid[g] = valid_q;
    assign grp_edge[g]  = rise & armed_q;
    assign grp_tmo[g]   = tmo;
    assign grp_tone[g]  = tone_q;
    assign grp_cnt[g]   = cnt_q;
  end

  assign early_steer = &grp_valid;
  assign digit_code  = early_steer ? key_code(grp_tone[0], grp_tone[1]) : 4'd0;

endmodule

// File: rtl/dtmf_period_detector_chk.sv
module dtmf_period_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       early_steer,
  input logic [3:0] digit_code,
  input logic [1:0] grp_valid,
  input logic [1:0] grp_edge,
  input logic [1:0] grp_tmo,
  input logic [1:0] cnt_zero
);

  assert_acquire_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_valid[0]) |-> $past(grp_edge[0]));
  assert_acquire_hi_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_valid[1]) |-> $past(grp_edge[1]));
  assert_steer_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(early_steer) |-> $past(|grp_edge));
  assert_timeout_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_tmo[0] |=> !grp_valid[0]);
  assert_timeout_hi_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grp_tmo[1] |=> !grp_valid[1]);
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero[0] |=> !cnt_zero[0]);
  assert_no_wrap_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero[1] |=> !cnt_zero[1]);
  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (early_steer && $past(early_steer)) |-> $stable(digit_code));

endmodule

bind dtmf_period_detector dtmf_period_detector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .early_steer(early_steer),
  .digit_code (digit_code),
  .grp_valid  (grp_valid),
  .grp_edge   (grp_edge),
  .grp_tmo    (grp_tmo),
  .cnt_zero   ({grp_cnt[1] == '0, grp_cnt[0] == '0})
);

// File: tb/sim_dtmf_period_detector.sv
module sim_dtmf_period_detector;
  localparam int CLK = 400000;

  logic clk = 1'b0, rst_n = 1'b0, lo = 1'b0, hi = 1'b0;
  logic early_steer;
  logic [3:0] digit_code;

  dtmf_period_detector #(.CLK_HZ(CLK)) u0 (
    .clk(clk), .rst_n(rst_n), .tone_lo_i(lo), .tone_hi_i(hi),
    .early_steer(early_steer), .digit_code(digit_code));

  always #10 clk = ~clk;

  real lo_f [4] = '{697.0, 770.0, 852.0, 941.0};
  real hi_f [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
  real f_lo = 0.0, f_hi = 0.0, ph_lo = 0.0, ph_hi = 0.0;
  bit  en_lo = 0, en_hi = 0;
  int  rises_hi = 0;
  int  n_vec = 0, n_err = 0;

  always @(negedge clk) begin
    if (en_lo) begin
      ph_lo += f_lo / real'(CLK);
      if (ph_lo >= 0.5) begin ph_lo -= 0.5; lo = ~lo; end
    end
    if (en_hi) begin
      ph_hi += f_hi / real'(CLK);
      if (ph_hi >= 0.5) begin
        ph_hi -= 0.5; hi = ~hi;
        if (hi) rises_hi++;
      end
    end
  end

  typedef struct { bit est; logic [3:0] code; string tag; } exp_t;
  exp_t q[$];

  initial forever begin
    exp_t e;
    wait (q.size() != 0);
    @(negedge clk);
    e = q.pop_front();
    n_vec++;
    if (early_steer !== e.est || digit_code !== e.code) begin
      n_err++;
      $display("FAIL %s: est=%0b code=%0d, expected est=%0b code=%0d",
               e.tag, early_steer, digit_code, e.est, e.code);
    end
  end

  task automatic expect_now(bit est, logic [3:0] code, string tag);
    exp_t e;
    e.est = est; e.code = code; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    @(posedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_code(int r, int c);
    string keys = "123A456B789C*0#D";
    byte ch = keys[r * 4 + c];
    if (ch >= "1" && ch <= "9") return 4'(ch - "0");
    case (ch)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic play(real flo, real fhi, bit use_lo, bit use_hi, int n);
    f_lo = flo; f_hi = fhi; en_lo = use_lo; en_hi = use_hi;
    idle(n);
  endtask

  task automatic quiet();
    en_lo = 0; en_hi = 0;
    idle(1300);
  endtask

  task automatic bad_periods(int k, real fbad, real fgood);
    int start;
    start = rises_hi;
    f_hi = fbad;
    wait (rises_hi == start + 1);
    wait (rises_hi == start + 1 + k);
    f_hi = fgood;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    idle(10);
    expect_now(1'b0, 4'd0, "R1 reset");
    rst_n = 1'b1;
    idle(5);

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        play(lo_f[r], hi_f[c], 1, 1, 4000);
        expect_now(1'b1, ref_code(r, c), "R2 R8 pair decode");
        quiet();
        expect_now(1'b0, 4'd0, "R6 R9 idle after tone");
      end

    play(lo_f[1], hi_f[2], 1, 0, 4000);
    expect_now(1'b0, 4'd0, "R5 low band only");
    quiet();
    play(lo_f[1], hi_f[2], 0, 1, 4000);
    expect_now(1'b0, 4'd0, "R5 high band only");
    quiet();

    play(lo_f[0] * 1.015 + 2.0, hi_f[3] * 1.015 + 2.0, 1, 1, 4000);
    expect_now(1'b1, 4'd13, "R3 upper accept edge");
    quiet();
    play(lo_f[3] * 0.985 - 2.0, hi_f[0] * 0.985 - 2.0, 1, 1, 4000);
    expect_now(1'b1, 4'd11, "R3 lower accept edge");
    quiet();

    play(lo_f[0], hi_f[1] * 1.035, 1, 1, 4000);
    expect_now(1'b0, 4'd0, "R4 high band +3.5%");
    quiet();
    play(lo_f[2] * 0.965, hi_f[0], 1, 1, 4000);
    expect_now(1'b0, 4'd0, "R4 low band -3.5%");
    quiet();

    play(lo_f[1], hi_f[1], 1, 1, 4000);
    expect_now(1'b1, 4'd5, "R6 before high band stops");
    en_hi = 0;
    idle(700);
    expect_now(1'b0, 4'd0, "R6 timeout after high band stops");
    quiet();

    play(lo_f[1], hi_f[1], 1, 1, 4000);
    begin
      int drops = 0;
      fork
        bad_periods(1, hi_f[1] * 1.06, hi_f[1]);
        begin
          repeat (1500) begin
            @(negedge clk);
            if (early_steer !== 1'b1 || digit_code !== 4'd5) drops++;
          end
        end
      join
      check(drops == 0, "R7 single bad period tolerated", drops, 0);
    end

    begin
      int low_seen = 0;
      fork
        bad_periods(2, hi_f[1] * 1.06, hi_f[1]);
        begin
          repeat (1500) begin
            @(negedge clk);
            if (early_steer === 1'b0) low_seen = 1;
          end
        end
      join
      check(low_seen == 1, "R7 two bad periods clear band", low_seen, 1);
    end
    idle(2000);
    expect_now(1'b1, 4'd5, "R7 reacquire after drop");
    quiet();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule